// File: doc/BRIEF.md
# JTAG Configuration Load Sequencer

This block is a host-side controller that configures a target device through its four-wire JTAG Test Access Port. After a start pulse it resets the target TAP and loads a program opcode. It then polls a readiness flag by loading the configuration-input opcode again and again, reading bit 4 of the instruction-register value that the target captures and shifts out during each scan. Once the flag reads 1, it streams the whole bitstream into the data register. It then returns the TAP to Test-Logic-Reset, loads the start opcode and gives a fixed run of idle clocks before it reports completion.

TCK comes from the system clock through a parameterized divider. TMS and TDI are updated while TCK is low, and TDO is sampled when TCK rises. The bitstream arrives as words on a valid/ready stream with a last marker. If no word is offered, TCK is held high until one arrives. The instruction length, all three opcodes, the poll bit, the poll limit, the reset run and the idle-tail length are parameters. Every scan starts and ends in Run-Test-Idle.

Top module: `jtag_cfg_loader`

## Requirements
- R1: After start, and again after the bitstream, TMS is held at 1 for RST_TCKS (5) consecutive rising TCK edges, which brings the TAP to Test-Logic-Reset. No other stretch of the run holds TMS at 1 for that many edges.
- R2: The first instruction scan after start loads OP_PROG. Every instruction word is shifted LSB first, with TMS at 1 only on its final bit.
- R3: After the program scan, the block repeats OP_CFGIN instruction scans. Bit k of the captured value is the TDO level at the k-th shift edge. Polling stops at the first scan whose bit POLL_BIT (4) is 1.
- R4: If POLL_MAX scans in a row capture bit POLL_BIT as 0, timeout goes to 1 and done stays 0. In that case no data-register scan is made and no stream word is accepted.
- R5: After a successful poll, a single Shift-DR scan carries every stream word in arrival order, each word LSB first. TMS is 1 only on the final bit of the word flagged last.
- R6: A word is taken only in a cycle with s_valid and s_ready both 1, and s_ready is 1 only while the data scan waits for its next word. While no word is offered, TCK stays high.
- R7: After the reset of R1, one OP_START instruction scan follows. Then exactly TAIL_TCKS (12) rising TCK edges occur in Run-Test-Idle, then done goes to 1.
- R8: Each TCK high or low phase lasts at least DIV system clocks. TMS and TDI change only while TCK is low.
- R9: After reset, tck, busy, done, timeout and s_ready are 0. Done or timeout stays set with TCK low until the next start, which clears both and runs the full sequence again. TCK is low whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a configuration run when not busy |
| s_data | input | WORD_W | Bitstream word |
| s_valid | input | 1 | s_data holds a word |
| s_last | input | 1 | Marks the final bitstream word |
| s_ready | output | 1 | Word accepted this cycle when s_valid is 1 |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Serial data to the target |
| tdo | input | 1 | Serial data from the target |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished normally |
| timeout | output | 1 | Last run gave up polling |

## Verification
The assertions assume a target whose TDO changes only after a falling TCK edge, so a level sampled at a rising edge is settled. They also assume that start is pulsed only while busy is 0 and that the stream keeps s_data and s_last steady while s_valid waits. The bench's target model drives TDO only from the negative TCK edge. Its feeder changes the stream signals only on falling system-clock edges and does so only after a handshake, and start is raised only once the previous run has ended.

// File: rtl/jtag_cfg_loader.sv
module jtag_cfg_loader #(
  parameter int IR_LEN = 6,
  parameter logic [IR_LEN-1:0] OP_PROG  = 6'h0B,
  parameter logic [IR_LEN-1:0] OP_CFGIN = 6'h05,
  parameter logic [IR_LEN-1:0] OP_START = 6'h0C,
  parameter int POLL_BIT  = 4,
  parameter int POLL_MAX  = 64,
  parameter int DIV       = 4,
  parameter int WORD_W    = 8,
  parameter int RST_TCKS  = 5,
  parameter int TAIL_TCKS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  localparam int SRW  = (IR_LEN > WORD_W) ? IR_LEN : WORD_W;
  localparam int LM1  = (SRW > RST_TCKS) ? SRW : RST_TCKS;
  localparam int LMAX = (LM1 > TAIL_TCKS) ? LM1 : TAIL_TCKS;
  localparam int CW   = $clog2(LMAX + 1);
  localparam int PW   = $clog2(POLL_MAX + 1);
  localparam int DW   = $clog2(DIV + 1);

  typedef enum logic [3:0] {
    PH_IDLE, PH_NEXT, PH_RST, PH_WALK, PH_SHIR, PH_SHDR, PH_TAIL, PH_DONE, PH_TOUT
  } phase_t;

  phase_t            phase;
  logic [4:0]        pc;
  logic [CW-1:0]     left;
  logic [SRW-1:0]    sr;
  logic [3:0]        wbits;
  logic [IR_LEN-1:0] cap;
  logic              capf, lastw, fresh;
  logic [PW-1:0]     polls;
  logic [DW-1:0]     dcnt;

  wire tck_ph    = phase inside {PH_RST, PH_WALK, PH_SHIR, PH_SHDR, PH_TAIL};
  wire term      = dcnt == DW'(DIV - 1);
  wire edge_now  = tck_ph && (fresh || (tck && term));
  wire need_word = phase == PH_SHDR && left == '0 && !lastw;
  wire stall     = need_word && !s_valid;
  wire pres      = edge_now && !stall;
  wire rise      = tck_ph && !fresh && !tck && term;

  assign s_ready = edge_now && need_word;
  assign busy    = !(phase inside {PH_IDLE, PH_DONE, PH_TOUT});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      tck  <= 1'b0;
    end else if (!tck_ph || fresh) begin
      dcnt <= '0;
    end else if (term) begin
      if (!(tck && stall)) begin
        dcnt <= '0;
        tck  <= ~tck;
      end
    end else begin
      dcnt <= dcnt + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; pc <= '0; left <= '0; sr <= '0; wbits <= '0;
      cap <= '0; capf <= 1'b0; lastw <= 1'b0; fresh <= 1'b0; polls <= '0;
      tms <= 1'b1; tdi <= 1'b0; done <= 1'b0; timeout <= 1'b0;
    end else begin
      if (rise && capf) cap <= {tdo, cap[IR_LEN-1:1]};
      case (phase)
        PH_IDLE, PH_DONE, PH_TOUT: begin
          if (start) begin
            phase <= PH_NEXT; pc <= '0; polls <= '0;
            done <= 1'b0; timeout <= 1'b0;
          end
        end
        PH_NEXT: begin
          fresh <= 1'b1;
          pc    <= pc + 5'd1;
          case (pc)
            5'd0, 5'd12: begin phase <= PH_RST; left <= CW'(RST_TCKS); end
            5'd1, 5'd13: begin phase <= PH_WALK; wbits <= 4'b0000; left <= CW'(1); end
            5'd2, 5'd5, 5'd14: begin phase <= PH_WALK; wbits <= 4'b0011; left <= CW'(4); end
            5'd4, 5'd7, 5'd11, 5'd16: begin phase <= PH_WALK; wbits <= 4'b0001; left <= CW'(2); end
            5'd9: begin phase <= PH_WALK; wbits <= 4'b0001; left <= CW'(3); end
            5'd3: begin phase <= PH_SHIR; sr <= SRW'(OP_PROG); left <= CW'(IR_LEN); end
            5'd6: begin phase <= PH_SHIR; sr <= SRW'(OP_CFGIN); left <= CW'(IR_LEN); end
            5'd15: begin phase <= PH_SHIR; sr <= SRW'(OP_START); left <= CW'(IR_LEN); end
            5'd8: begin
              if (!cap[POLL_BIT]) begin
                if (polls == PW'(POLL_MAX - 1)) begin
                  phase <= PH_TOUT; timeout <= 1'b1;
                end else begin
                  polls <= polls + PW'(1); pc <= 5'd5;
                end
              end
            end
            5'd10: begin phase <= PH_SHDR; left <= '0; lastw <= 1'b0; end
            5'd17: begin phase <= PH_TAIL; left <= CW'(TAIL_TCKS); end
            default: begin phase <= PH_DONE; done <= 1'b1; end
          endcase
        end
        default: begin
          if (pres) begin
            fresh <= 1'b0;
            capf  <= 1'b0;
            if (need_word) begin
              tdi   <= s_data[0];
              sr    <= SRW'(s_data >> 1);
              left  <= CW'(WORD_W - 1);
              lastw <= s_last;
              tms   <= s_last && (WORD_W == 1);
            end else if (left == '0) begin
              phase <= PH_NEXT;
            end else begin
              left <= left - CW'(1);
              case (phase)
                PH_WALK: begin tms <= wbits[0]; wbits <= wbits >> 1; end
                PH_SHIR: begin tdi <= sr[0]; sr <= sr >> 1; tms <= left == CW'(1); capf <= 1'b1; end
                PH_SHDR: begin tdi <= sr[0]; sr <= sr >> 1; tms <= lastw && left == CW'(1); end
                PH_TAIL: tms <= 1'b0;
                default: begin tms <= 1'b1; tdi <= 1'b0; end
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/jtag_cfg_loader_chk.sv
module jtag_cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic s_ready,
  input logic busy,
  input logic done,
  input logic timeout
);
  // R8
  tms_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tms) |-> !tck);
  // R8
  tdi_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdi) |-> !tck);
  // R9
  idle_tck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);
  // R6
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy);
  // R4
  end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  // R7
  done_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

bind jtag_cfg_loader jtag_cfg_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
  .s_ready(s_ready), .busy(busy), .done(done), .timeout(timeout)
);

// File: tb/jtag_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module jtag_cfg_loader_tb_top;
  localparam int PMAX = 4;
  localparam int DV = 3;
  localparam logic [5:0] PROG = 6'h0B, CFGIN = 6'h05, STRT = 6'h0C;
  localparam int TLR = 0, RTI = 1, SDS = 2, CDR = 3, SDR = 4, E1D = 5, PDR = 6, E2D = 7,
                 UDR = 8, SIS = 9, CIR = 10, SIR = 11, E1I = 12, PIR = 13, E2I = 14, UIR = 15;

  logic clk = 0, rst_n = 0, start = 0, s_valid = 0, s_last = 0, tdo, mdl_clr = 0;
  logic [7:0] s_data = '0;
  logic s_ready, tck, tms, tdi, busy, done, timeout;
  int checks = 0, failures = 0, cyc = 0, tviol = 0, thr = 1, nacc = 0;
  logic wd_hit = 0;

  always #2.5 clk = ~clk;

  jtag_cfg_loader #(.POLL_MAX(PMAX), .DIV(DV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .busy(busy), .done(done), .timeout(timeout));

  function automatic int nxt(int s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;  RTI: return m ? SDS : RTI;
      SDS: return m ? SIS : CDR;  CDR: return m ? E1D : SDR;
      SDR: return m ? E1D : SDR;  E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;  E2D: return m ? UDR : SDR;
      UDR: return m ? SDS : RTI;  SIS: return m ? TLR : CIR;
      CIR: return m ? E1I : SIR;  SIR: return m ? E1I : SIR;
      E1I: return m ? UIR : PIR;  PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SIR;  default: return m ? SDS : RTI;
    endcase
  endfunction

  int st, ncap, n_prog, n_cfg, n_start, ord_err, rxn, rti_cnt, ones, max_ones;
  logic saw_tlr;
  logic [5:0] ir, irsh;
  logic [63:0] rxv;

  always @(posedge tck or posedge mdl_clr) begin
    if (mdl_clr) begin
      st = TLR; ncap = 0; n_prog = 0; n_cfg = 0; n_start = 0; ord_err = 0; rxn = 0;
      rti_cnt = 0; ones = 0; max_ones = 0; saw_tlr = 0; ir = '0; irsh = '0; rxv = '0;
    end else begin
      ones = tms ? ones + 1 : 0;
      if (ones > max_ones) max_ones = ones;
      case (st)
        TLR: begin ir = '0; if (rxn > 0) saw_tlr = 1; end
        RTI: if (ir == STRT) rti_cnt++;
        CIR: begin irsh = (ncap >= thr) ? 6'h11 : 6'h01; ncap++; end
        SIR: irsh = {tdi, irsh[5:1]};
        SDR: if (ir == CFGIN) begin if (rxn < 64) rxv[rxn] = tdi; rxn++; end
        UIR: begin
          ir = irsh;
          if (ir == PROG) begin if (n_prog != 0 || n_cfg != 0) ord_err++; n_prog++; end
          else if (ir == CFGIN) begin if (n_prog != 1 || n_start != 0) ord_err++; n_cfg++; end
          else if (ir == STRT) begin if (!saw_tlr) ord_err++; n_start++; end
          else ord_err++;
        end
        default: ;
      endcase
      st = nxt(st, tms);
    end
  end

  always @(negedge tck or posedge mdl_clr)
    if (mdl_clr) tdo <= 1'b0;
    else tdo <= (st == SIR) ? irsh[0] : 1'b0;

  int run_len = 0;
  logic ptck = 0, ptms = 1, ptdi = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) wd_hit = 1;
    if (rst_n) begin
      if (tck != ptck) begin if (run_len < DV) tviol++; run_len = 1; end
      else run_len++;
      if (tck && (tms != ptms || tdi != ptdi)) tviol++;
    end
    ptck = tck; ptms = tms; ptdi = tdi;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] word(int run, int i);
    return 8'(run * 37 + i * 91 + 29);
  endfunction

  task automatic feed(int run, int nw);
    for (int i = 0; i < nw; i++) begin
      logic acc;
      if (i % 3 != 0) begin s_valid = 0; repeat (i % 3) @(negedge clk); end
      s_valid = 1; s_data = word(run, i); s_last = (i == nw - 1);
      acc = 0;
      while (!acc && !(done || timeout || wd_hit)) begin
        @(negedge clk);
        if (s_ready) begin @(posedge clk); acc = 1; nacc++; @(negedge clk); end
      end
      if (!acc) break;
    end
    s_valid = 0; s_last = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset tck", int'(tck), 0);
    chk("R9 reset busy/done/timeout/ready", int'({busy, done, timeout, s_ready}), 0);
    rst_n = 1;
    for (int run = 1; run <= PMAX + 1; run++) begin
      int nw, edges, bad;
      logic ok;
      thr = run; nw = (run % 3) + 1; ok = (thr <= PMAX); nacc = 0;
      mdl_clr = 1; @(negedge clk); mdl_clr = 0;
      start = 1; @(negedge clk); start = 0;
      chk("R9 start clears done/timeout", int'({done, timeout}), 0);
      fork
        feed(run, nw);
        while (!(done || timeout || wd_hit)) @(negedge clk);
      join
      edges = 0;
      for (int k = 0; k < 40; k++) begin @(negedge clk); if (tck) edges++; end
      chk("R9 tck low after end", edges, 0);
      chk("R9 busy low after end", int'(busy), 0);
      chk("R1 longest TMS-high run", max_ones, 5);
      chk("R2 instruction order", ord_err, 0);
      chk("R2 program scans", n_prog, 1);
      if (ok) begin
        chk("R7 done held", int'(done), 1);
        chk("R4 no timeout", int'(timeout), 0);
        chk("R3 poll scans", n_cfg, thr);
        chk("R6 words accepted", nacc, nw);
        chk("R5 data bits shifted", rxn, nw * 8);
        bad = 0;
        for (int i = 0; i < nw; i++)
          for (int b = 0; b < 8; b++)
            if (rxv[i * 8 + b] != word(run, i)[b]) bad++;
        chk("R5 data bit mismatches", bad, 0);
        chk("R1 reset reached after data", int'(saw_tlr), 1);
        chk("R7 start scans", n_start, 1);
        chk("R7 idle TCK edges", rti_cnt, 12);
      end else begin
        chk("R4 timeout held", int'(timeout), 1);
        chk("R4 done stays low", int'(done), 0);
        chk("R4 poll scans", n_cfg, PMAX);
        chk("R4 no data bits", rxn, 0);
        chk("R4 no words accepted", nacc, 0);
        chk("R4 no start scan", n_start, 0);
      end
    end
    chk("R8 tck phase and edge violations", tviol, 0);
    if (wd_hit) begin
      checks++; failures++;
      $display("FAIL R9 watchdog expired actual=%0d expected=0", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (wd_hit);
    s_valid = 0;
  end
endmodule